// File: doc/BRIEF.md
# Tick-Driven Time-of-Day Counter with Day Count and Alarm

This block keeps time of day from a periodic enable pulse. Each pulse advances a subsecond count. Its overflow advances seconds, then minutes and hours, and the hour overflow advances an elapsed-day count. The day count has no months or years; it counts days and wraps at its width.

Software reaches every count, the three alarm compare fields, a control word and a status flag through a flat register port. Writes are synchronous and reads are combinational.

The alarm is checked only when the seconds change. A mode field selects the comparison:
- a full hour:minute:second match, once a day;
- minute and second, once an hour;
- second only, once a minute;
- no comparison, every second.

A match sets a sticky flag, and the interrupt line is that flag gated by an enable bit.

Top module: `daytime_keeper`

## Requirements
- R1: After reset all time counts, alarm fields, the control word and the alarm flag read 0, and `irq_o` is low.
- R2: Each `tick_i` pulse that is not dropped (see R6) adds one to the subsecond count. At 2^SUB_W ticks it returns to 0 and adds one to the seconds.
- R3: The seconds count wraps from SEC_PER_MIN-1 to 0 and carries into the minutes. The minutes wrap from MIN_PER_HOUR-1 to 0 and carry into the hours. The hours wrap from HOUR_PER_DAY-1 to 0 and add one to the day count.
- R4: The day count is DAY_W bits wide and wraps from its all-ones value to 0.
- R5: The register addresses are:

  | Address | Contents |
  |---|---|
  | 0 | subsecond |
  | 1 | second |
  | 2 | minute |
  | 3 | hour |
  | 4 | day |
  | 5 | alarm second |
  | 6 | alarm minute |
  | 7 | alarm hour |
  | 8 | control: bits 1:0 are the mode, bit 2 is the interrupt enable |
  | 9 | status: bit 0 is the flag |

  Writes take effect at the next clock edge. Reads are combinational and zero-extended, and unmapped addresses read 0.
- R6: In a cycle with a write to any time register (addresses 0 to 4), the written field takes the written value and `tick_i` is discarded, so no other field moves.
- R7: The alarm is evaluated only on a tick that wraps the subsecond count. It compares against the time as it stands after that tick.
- R8: Mode 0 (daily) sets the flag when hour, minute and second all equal the alarm fields.
- R9: Mode 1 (hourly) sets the flag when minute and second equal the alarm fields, whatever the hour.
- R10: Mode 2 (per minute) sets the flag when the second equals the alarm second.
- R11: Mode 3 (per second) sets the flag on every subsecond wrap.
- R12: The flag stays set until software writes 1 to status bit 0. Writing 0 has no effect. If a match and a clear fall in the same cycle, the flag stays set.
- R13: `irq_o` is high exactly when the flag is set and control bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle subsecond advance pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
The bench builds the block with a one-bit subsecond, four seconds per minute, three minutes per hour, two hours per day and a three-bit day count. With these values a whole day is 48 ticks and the day count wraps after 384 ticks. That brings every rollover, including the day wrap, into a tick-by-tick sweep compared against quotient and remainder arithmetic. The same small time space lets every alarm mode run over a full day for eight alarm settings, with the exact tick of each expected interrupt computed from the alarm fields.

// File: rtl/dtk_pkg.sv
`timescale 1ns/1ps
package dtk_pkg;

   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] ADR_SUB   = 4'd0;
   localparam logic [ADDR_W-1:0] ADR_SEC   = 4'd1;
   localparam logic [ADDR_W-1:0] ADR_MIN   = 4'd2;
   localparam logic [ADDR_W-1:0] ADR_HOUR  = 4'd3;
   localparam logic [ADDR_W-1:0] ADR_DAY   = 4'd4;
   localparam logic [ADDR_W-1:0] ADR_ASEC  = 4'd5;
   localparam logic [ADDR_W-1:0] ADR_AMIN  = 4'd6;
   localparam logic [ADDR_W-1:0] ADR_AHOUR = 4'd7;
   localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'd8;
   localparam logic [ADDR_W-1:0] ADR_STAT  = 4'd9;

   typedef enum logic [1:0] {
      ALM_DAILY  = 2'd0,
      ALM_HOURLY = 2'd1,
      ALM_MINUTE = 2'd2,
      ALM_SECOND = 2'd3
   } alarm_mode_e;

endpackage

// File: rtl/dtk_wrap_counter.sv
`timescale 1ns/1ps
// Modulo-MOD counter with load; presents its next value for look-ahead compare.
module dtk_wrap_counter #(
   parameter int MOD = 60,
   parameter int W   = (MOD > 1) ? $clog2(MOD) : 1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic [W-1:0] count_nxt,
   output logic         at_top
);

   localparam logic [W-1:0] TOP = W'(MOD - 1);

   logic [W-1:0] step;

   generate
      if (MOD < 2) begin : g_bad_mod
         $error("dtk_wrap_counter: MOD must be at least 2");
      end
      if ((1 << W) == MOD) begin : g_pow2
         // natural binary overflow is the wrap
         assign step = count + W'(1);
      end else begin : g_modn
         assign step = (count == TOP) ? '0 : count + W'(1);
      end
   endgenerate

   assign at_top = (count == TOP);

   always_comb begin
      if (load)     count_nxt = load_val;
      else if (inc) count_nxt = step;
      else          count_nxt = count;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= count_nxt;
   end

endmodule

// File: rtl/dtk_alarm_match.sv
`timescale 1ns/1ps
// Alarm comparator: evaluates the post-update time at a seconds boundary.
module dtk_alarm_match
   import dtk_pkg::*;
#(
   parameter int SEC_W  = 6,
   parameter int MIN_W  = 6,
   parameter int HOUR_W = 5
)(
   input  logic              boundary,
   input  alarm_mode_e       mode,
   input  logic [SEC_W-1:0]  sec_nxt,
   input  logic [MIN_W-1:0]  min_nxt,
   input  logic [HOUR_W-1:0] hour_nxt,
   input  logic [SEC_W-1:0]  alm_sec,
   input  logic [MIN_W-1:0]  alm_min,
   input  logic [HOUR_W-1:0] alm_hour,
   output logic              hit
);

   logic sec_eq, min_eq, hour_eq, match;

   always_comb begin
      sec_eq  = (sec_nxt == alm_sec);
      min_eq  = (min_nxt == alm_min);
      hour_eq = (hour_nxt == alm_hour);
      case (mode)
         ALM_DAILY:  match = sec_eq && min_eq && hour_eq;
         ALM_HOURLY: match = sec_eq && min_eq;
         ALM_MINUTE: match = sec_eq;
         default:    match = 1'b1;
      endcase
      hit = boundary && match;
   end

endmodule

// File: rtl/daytime_keeper.sv
`timescale 1ns/1ps
module daytime_keeper
   import dtk_pkg::*;
#(
   parameter int SUB_W        = 8,
   parameter int SEC_PER_MIN  = 60,
   parameter int MIN_PER_HOUR = 60,
   parameter int HOUR_PER_DAY = 24,
   parameter int DAY_W        = 16,
   parameter int DATA_W       = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);

   localparam int SEC_W  = $clog2(SEC_PER_MIN);
   localparam int MIN_W  = $clog2(MIN_PER_HOUR);
   localparam int HOUR_W = $clog2(HOUR_PER_DAY);

   generate
      if (DATA_W < DAY_W || DATA_W < SUB_W || DATA_W < 3) begin : g_bad_data
         $error("daytime_keeper: DATA_W too narrow for a field");
      end
      if (SEC_PER_MIN < 2 || MIN_PER_HOUR < 2 || HOUR_PER_DAY < 2) begin : g_bad_mod
         $error("daytime_keeper: every time modulus must be at least 2");
      end
   endgenerate

   // ---- write decode ----
   logic time_wr, tick_eff, flag_clr;
   assign time_wr  = wr_en_i && (addr_i <= ADR_DAY);
   assign tick_eff = tick_i && !time_wr;          // a time load discards the tick (R6)
   assign flag_clr = wr_en_i && (addr_i == ADR_STAT) && wr_data_i[0];

   // ---- carry chain ----
   logic sub_top, sec_top, min_top, hour_top, day_top;
   logic sec_inc, min_inc, hour_inc, day_inc;
   assign sec_inc  = tick_eff && sub_top;
   assign min_inc  = sec_inc  && sec_top;
   assign hour_inc = min_inc  && min_top;
   assign day_inc  = hour_inc && hour_top;

   logic [SUB_W-1:0]  sub_cnt,  sub_nxt;
   logic [SEC_W-1:0]  sec_cnt,  sec_nxt;
   logic [MIN_W-1:0]  min_cnt,  min_nxt;
   logic [HOUR_W-1:0] hour_cnt, hour_nxt;
   logic [DAY_W-1:0]  day_cnt,  day_nxt;

   dtk_wrap_counter #(.MOD(1 << SUB_W), .W(SUB_W)) u_sub (
      .clk(clk), .rst_n(rst_n), .inc(tick_eff),
      .load(wr_en_i && addr_i == ADR_SUB), .load_val(wr_data_i[SUB_W-1:0]),
      .count(sub_cnt), .count_nxt(sub_nxt), .at_top(sub_top));

   dtk_wrap_counter #(.MOD(SEC_PER_MIN), .W(SEC_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(sec_inc),
      .load(wr_en_i && addr_i == ADR_SEC), .load_val(wr_data_i[SEC_W-1:0]),
      .count(sec_cnt), .count_nxt(sec_nxt), .at_top(sec_top));

   dtk_wrap_counter #(.MOD(MIN_PER_HOUR), .W(MIN_W)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(min_inc),
      .load(wr_en_i && addr_i == ADR_MIN), .load_val(wr_data_i[MIN_W-1:0]),
      .count(min_cnt), .count_nxt(min_nxt), .at_top(min_top));

   dtk_wrap_counter #(.MOD(HOUR_PER_DAY), .W(HOUR_W)) u_hour (
      .clk(clk), .rst_n(rst_n), .inc(hour_inc),
      .load(wr_en_i && addr_i == ADR_HOUR), .load_val(wr_data_i[HOUR_W-1:0]),
      .count(hour_cnt), .count_nxt(hour_nxt), .at_top(hour_top));

   dtk_wrap_counter #(.MOD(1 << DAY_W), .W(DAY_W)) u_day (
      .clk(clk), .rst_n(rst_n), .inc(day_inc),
      .load(wr_en_i && addr_i == ADR_DAY), .load_val(wr_data_i[DAY_W-1:0]),
      .count(day_cnt), .count_nxt(day_nxt), .at_top(day_top));

   // ---- alarm configuration ----
   logic [SEC_W-1:0]  alm_sec_q;
   logic [MIN_W-1:0]  alm_min_q;
   logic [HOUR_W-1:0] alm_hour_q;
   alarm_mode_e       mode_q;
   logic              ie_q;
   logic              flag_q;
   logic              alarm_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alm_sec_q  <= '0;
         alm_min_q  <= '0;
         alm_hour_q <= '0;
         mode_q     <= ALM_DAILY;
         ie_q       <= 1'b0;
      end else if (wr_en_i) begin
         case (addr_i)
            ADR_ASEC:  alm_sec_q  <= wr_data_i[SEC_W-1:0];
            ADR_AMIN:  alm_min_q  <= wr_data_i[MIN_W-1:0];
            ADR_AHOUR: alm_hour_q <= wr_data_i[HOUR_W-1:0];
            ADR_CTRL: begin
               mode_q <= alarm_mode_e'(wr_data_i[1:0]);
               ie_q   <= wr_data_i[2];
            end
            default: ;
         endcase
      end
   end

   dtk_alarm_match #(.SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W)) u_match (
      .boundary(sec_inc), .mode(mode_q),
      .sec_nxt(sec_nxt), .min_nxt(min_nxt), .hour_nxt(hour_nxt),
      .alm_sec(alm_sec_q), .alm_min(alm_min_q), .alm_hour(alm_hour_q),
      .hit(alarm_hit));

   // a new match outranks a same-cycle clear
   always_ff @(posedge clk) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (alarm_hit) flag_q <= 1'b1;
      else if (flag_clr)  flag_q <= 1'b0;
   end

   assign irq_o = flag_q && ie_q;

   // ---- read mux ----
   always_comb begin
      rd_data_o = '0;
      case (addr_i)
         ADR_SUB:   rd_data_o = DATA_W'(sub_cnt);
         ADR_SEC:   rd_data_o = DATA_W'(sec_cnt);
         ADR_MIN:   rd_data_o = DATA_W'(min_cnt);
         ADR_HOUR:  rd_data_o = DATA_W'(hour_cnt);
         ADR_DAY:   rd_data_o = DATA_W'(day_cnt);
         ADR_ASEC:  rd_data_o = DATA_W'(alm_sec_q);
         ADR_AMIN:  rd_data_o = DATA_W'(alm_min_q);
         ADR_AHOUR: rd_data_o = DATA_W'(alm_hour_q);
         ADR_CTRL:  rd_data_o = DATA_W'({ie_q, mode_q});
         ADR_STAT:  rd_data_o = DATA_W'(flag_q);
         default:   rd_data_o = '0;
      endcase
   end

endmodule

// File: rtl/daytime_keeper_chk.sv
`timescale 1ns/1ps
module daytime_keeper_chk #(
   parameter int SUB_W  = 8,
   parameter int SEC_W  = 6,
   parameter int MIN_W  = 6,
   parameter int HOUR_W = 5,
   parameter int DAY_W  = 16,
   parameter int SEC_PER_MIN  = 60,
   parameter int MIN_PER_HOUR = 60,
   parameter int HOUR_PER_DAY = 24
)(
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic [3:0]        addr,
   input logic              time_wr,
   input logic [SUB_W-1:0]  sub,
   input logic [SEC_W-1:0]  sec,
   input logic [MIN_W-1:0]  min,
   input logic [HOUR_W-1:0] hour,
   input logic [DAY_W-1:0]  day,
   input logic              boundary,
   input logic [1:0]        mode,
   input logic              flag,
   input logic              clr,
   input logic              ie,
   input logic              irq
);

   localparam logic [SUB_W-1:0]  SUB_TOP  = '1;
   localparam logic [SEC_W-1:0]  SEC_TOP  = SEC_W'(SEC_PER_MIN - 1);
   localparam logic [MIN_W-1:0]  MIN_TOP  = MIN_W'(MIN_PER_HOUR - 1);
   localparam logic [HOUR_W-1:0] HOUR_TOP = HOUR_W'(HOUR_PER_DAY - 1);
   localparam logic [DAY_W-1:0]  DAY_TOP  = '1;

   logic day_roll;
   assign day_roll = tick && !time_wr && sub == SUB_TOP && sec == SEC_TOP &&
                     min == MIN_TOP && hour == HOUR_TOP;

   assert_sub_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !time_wr) |=> sub == SUB_W'($past(sub) + 1));

   assert_day_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      day_roll |=> (hour == '0 && day == DAY_W'($past(day) + 1)));

   assert_day_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (day_roll && day == DAY_TOP) |=> day == '0);

   assert_tick_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (time_wr && addr != 4'd0) |=> $stable(sub));

   assert_every_second_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && mode == 2'd3) |=> flag);

   assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

   assert_irq_gated_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !ie |-> !irq);

endmodule

bind daytime_keeper daytime_keeper_chk #(
   .SUB_W(SUB_W), .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W),
   .SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_HOUR(MIN_PER_HOUR), .HOUR_PER_DAY(HOUR_PER_DAY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick_i), .wr_en(wr_en_i), .addr(addr_i),
   .time_wr(time_wr), .sub(sub_cnt), .sec(sec_cnt), .min(min_cnt),
   .hour(hour_cnt), .day(day_cnt), .boundary(sec_inc), .mode(mode_q),
   .flag(flag_q), .clr(flag_clr), .ie(ie_q), .irq(irq_o)
);

// File: tb/sim_daytime_keeper.sv
`timescale 1ns/1ps
module sim_daytime_keeper;

   localparam int SW  = 1;
   localparam int SPM = 4;
   localparam int MPH = 3;
   localparam int HPD = 2;
   localparam int DW  = 3;
   localparam int DATA_W = 16;
   localparam int SUBS = 1 << SW;
   localparam int DAYS = 1 << DW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic              wr_en = 1'b0;
   logic [3:0]        addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rd_data;
   logic              irq;

   int ntests = 0;
   int nfail  = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   daytime_keeper #(
      .SUB_W(SW), .SEC_PER_MIN(SPM), .MIN_PER_HOUR(MPH),
      .HOUR_PER_DAY(HPD), .DAY_W(DW), .DATA_W(DATA_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
      .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rd_data), .irq_o(irq)
   );

   task automatic chk(string req, int act, int exp);
      ntests++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'(a); wdata = DATA_W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, output int v);
      @(negedge clk);
      addr = 4'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic tk();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   function automatic int f_sub(int t);  return t % SUBS; endfunction
   function automatic int f_sec(int t);  return (t / SUBS) % SPM; endfunction
   function automatic int f_min(int t);  return (t / (SUBS*SPM)) % MPH; endfunction
   function automatic int f_hour(int t); return (t / (SUBS*SPM*MPH)) % HPD; endfunction
   function automatic int f_day(int t);  return (t / (SUBS*SPM*MPH*HPD)) % DAYS; endfunction

   task automatic set_time(int t);
      wr(0, f_sub(t)); wr(1, f_sec(t)); wr(2, f_min(t));
      wr(3, f_hour(t)); wr(4, f_day(t));
   endtask

   task automatic check_time(int t);
      int v;
      rd(0, v); chk("R2 subsecond", v, f_sub(t));
      rd(1, v); chk("R3 second", v, f_sec(t));
      rd(2, v); chk("R3 minute", v, f_min(t));
      rd(3, v); chk("R3 hour", v, f_hour(t));
      rd(4, v); chk("R4 day", v, f_day(t));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         ntests++; nfail++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         $display("[TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every register, and R5 unmapped read
      for (int a = 0; a < 10; a++) begin
         rd(a, v); chk("R1 reset register", v, 0);
      end
      chk("R1 irq after reset", int'(irq), 0);
      rd(15, v); chk("R5 unmapped address", v, 0);

      // R5: alarm and control read back
      wr(5, 3); wr(6, 2); wr(7, 1); wr(8, 6);
      rd(5, v); chk("R5 alarm second", v, 3);
      rd(6, v); chk("R5 alarm minute", v, 2);
      rd(7, v); chk("R5 alarm hour", v, 1);
      rd(8, v); chk("R5 control", v, 6);
      wr(8, 0); wr(9, 1);

      // R2 R3 R4: tick-by-tick sweep past the day wrap
      set_time(0);
      for (int t = 1; t <= DAYS*SUBS*SPM*MPH*HPD + 16; t++) begin
         tk();
         check_time(t);
      end

      // R4: all fields at top, one tick returns everything to zero
      wr(0, SUBS-1); wr(1, SPM-1); wr(2, MPH-1); wr(3, HPD-1); wr(4, DAYS-1);
      tk();
      check_time(0);

      // R6: tick coinciding with a time write is dropped
      set_time(0);
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; addr = 4'd1; wdata = 16'd2;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      rd(0, v); chk("R6 subsecond held", v, 0);
      rd(1, v); chk("R6 second loaded", v, 2);

      // R7..R11: every mode over a full day for eight alarm settings
      for (int m = 0; m < 4; m++) begin
         for (int as_i = 0; as_i < 2; as_i++) begin
            for (int am_i = 0; am_i < 2; am_i++) begin
               for (int ah = 0; ah < 2; ah++) begin
                  int as_v;
                  int am_v;
                  as_v = as_i * (SPM-1);
                  am_v = am_i * (MPH-1);
                  wr(5, as_v); wr(6, am_v); wr(7, ah); wr(8, m | 4);
                  set_time(0);
                  wr(9, 1);
                  for (int t = 1; t <= SUBS*SPM*MPH*HPD; t++) begin
                     bit bnd;
                     bit hit;
                     bnd = (f_sub(t) == 0);
                     case (m)
                        0: hit = bnd && f_sec(t) == as_v && f_min(t) == am_v && f_hour(t) == ah;
                        1: hit = bnd && f_sec(t) == as_v && f_min(t) == am_v;
                        2: hit = bnd && f_sec(t) == as_v;
                        default: hit = bnd;
                     endcase
                     tk();
                     if (!bnd)        chk("R7 no alarm between seconds", int'(irq), 0);
                     else if (m == 0) chk("R8 daily alarm", int'(irq), int'(hit));
                     else if (m == 1) chk("R9 hourly alarm", int'(irq), int'(hit));
                     else if (m == 2) chk("R10 minute alarm", int'(irq), int'(hit));
                     else             chk("R11 per-second alarm", int'(irq), int'(hit));
                     if (irq) wr(9, 1);
                  end
               end
            end
         end
      end

      // R12 R13: enable gating, write-0 ignored, write-1 clears
      wr(8, 3);
      set_time(1);
      wr(9, 1);
      tk();
      chk("R13 irq masked", int'(irq), 0);
      rd(9, v); chk("R13 flag set while masked", v, 1);
      wr(9, 0);
      rd(9, v); chk("R12 write 0 ignored", v, 1);
      wr(8, 7);
      chk("R13 irq when enabled", int'(irq), 1);
      wr(9, 1);
      rd(9, v); chk("R12 flag cleared", v, 0);
      chk("R13 irq after clear", int'(irq), 0);

      // R12: match and clear in the same cycle, set wins
      set_time(1);
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; addr = 4'd9; wdata = 16'd1;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      rd(9, v); chk("R12 set beats clear", v, 1);
      rd(0, v); chk("R6 status write keeps tick", v, 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

endmodule